// File: doc/BRIEF.md
# Strap-Driven Transceiver Mode Loader

This block turns a 3-bit mode strap into the working configuration of a 10/100 Ethernet transceiver. While the active-low hardware reset is held, the block samples the strap pins on every clock. The value present on the last clock before reset is released becomes the default for these fields:

- the control fields (speed, auto-negotiation enable, power-down, duplex);
- the advertisement field;
- a carrier-sense policy;
- a repeater flag.

The same reset also latches a separate strap that picks the reduced-pin (RMII) or full (MII) MAC interface.

After reset, a simple register port can read and overwrite the control, advertisement and mode fields. Setting the soft-reset bit rebuilds the whole configuration from the register-held mode field, using the same decode as the straps. The pins are never looked at again. The bit clears itself two clocks after it is set.

One mode code (110) parks the transceiver in a sticky power-down. It is left only by writing a different mode code into the mode register and then issuing a soft reset.

Top module: `mode_strap_cfg`

## Requirements
- R1: On release of `hw_rst_n`, the outputs {`speed_100`,`an_enable`,`pwr_down`,`full_duplex`} take the value that the last sampled `strap_mode` selects: 000→0000, 001→0001, 010→1000, 011→1001, 100→1100, 101→1100, 110→0010, 111→1101.
- R2: On release of reset, `adv_abil` takes 0100 for modes 100 and 101, 1111 for mode 111, and 0000 otherwise.
- R3: `crs_on_tx` (carrier sense during transmit as well as receive) is 1 for modes 000, 010 and 100 and 0 otherwise. `repeater` is 1 only in mode 101.
- R4: `rmii_sel` is the `strap_rmii` value latched at reset release (0 = MII, 1 = RMII). It does not change afterwards, and a soft reset does not change it either.
- R5: Changes on `strap_mode` after reset release have no effect on any output or register, and no effect at a soft reset.
- R6: Register map, 5-bit address:
  - address 0 holds speed in bit 13, auto-negotiation in bit 12, power-down in bit 10, duplex in bit 8 and soft reset in bit 15;
  - address 4 holds the advertisement in bits 8:5;
  - address 18 holds the mode field in bits 7:5, which loads from `strap_mode` at reset.
  A write with bit 15 clear updates the fields, and the outputs follow on the next clock.
- R7: Writing address 0 with bit 15 set reads back bit 15 = 1 from the next clock. On the clock after that, every output except `rmii_sel` is rebuilt from the mode field using the R1–R3 decode. One clock later, bit 15 reads 0. Writes are ignored while bit 15 is set.
- R8: Mode 110, whether it comes from the strap or from a soft reset, forces `pwr_down` = 1. Clearing bit 10 of address 0 does not release it, and neither does a soft reset while the mode field is still 110. A soft reset with any other mode field releases it.
- R9: Register writes while `hw_rst_n` is low are ignored.
- R10: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Active-low hardware reset; the straps are sampled while it is low |
| strap_mode | input | 3 | Mode strap pins |
| strap_rmii | input | 1 | Interface-select strap (1 = RMII) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| speed_100 | output | 1 | 1 = 100 Mb/s |
| an_enable | output | 1 | Auto-negotiation enabled |
| full_duplex | output | 1 | Full duplex |
| pwr_down | output | 1 | Power-down request |
| adv_abil | output | 4 | Advertised abilities |
| rmii_sel | output | 1 | RMII interface selected |
| crs_on_tx | output | 1 | Carrier sense also asserted while transmitting |
| repeater | output | 1 | Repeater behaviour selected |

## Verification
All eight strap codes are applied directly at hardware reset. This shows that every row of the decode table lands on the right outputs. Random strap wiggling after reset, paired with random mode-field values before a soft reset, tells a soft reset that reads the register apart from one that resamples the pins. Directed cases cover three things: the sticky power-down exit, a write during a pending soft reset, and writes during hardware reset. Each of these separates an ignored write from an honoured one.

// File: rtl/mode_strap_cfg.sv
module mode_strap_cfg #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int MW = 3,
  parameter int ADVW = 4,
  parameter int CTRL_ADDR = 0,
  parameter int ADV_ADDR = 4,
  parameter int MODE_ADDR = 18
) (
  input  logic            clk,
  input  logic            hw_rst_n,
  input  logic [MW-1:0]   strap_mode,
  input  logic            strap_rmii,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            speed_100,
  output logic            an_enable,
  output logic            full_duplex,
  output logic            pwr_down,
  output logic [ADVW-1:0] adv_abil,
  output logic            rmii_sel,
  output logic            crs_on_tx,
  output logic            repeater
);
  localparam int CW = 4;
  localparam int FW = CW + ADVW + 2;
  localparam logic [MW-1:0] M_SLEEP = MW'(6);

  // decoded word: {spd, an, pd, dup, adv, crs_tx, rep}
  function automatic logic [FW-1:0] decode(input logic [MW-1:0] m);
    case (m)
      MW'(0):  decode = {4'b0000, ADVW'(4'b0000), 1'b1, 1'b0};
      MW'(1):  decode = {4'b0001, ADVW'(4'b0000), 1'b0, 1'b0};
      MW'(2):  decode = {4'b1000, ADVW'(4'b0000), 1'b1, 1'b0};
      MW'(3):  decode = {4'b1001, ADVW'(4'b0000), 1'b0, 1'b0};
      MW'(4):  decode = {4'b1100, ADVW'(4'b0100), 1'b1, 1'b0};
      MW'(5):  decode = {4'b1100, ADVW'(4'b0100), 1'b0, 1'b1};
      MW'(6):  decode = {4'b0010, ADVW'(4'b0000), 1'b0, 1'b0};
      default: decode = {4'b1101, ADVW'(4'b1111), 1'b0, 1'b0};
    endcase
  endfunction

  logic [CW-1:0]   ctrl_q;
  logic [ADVW-1:0] adv_q;
  logic [MW-1:0]   mode_q;
  logic            crs_q, rep_q, lock_q, rmii_q, srst_q, done_q;
  logic [FW-1:0]   strap_cfg, soft_cfg;

  assign strap_cfg = decode(strap_mode);
  assign soft_cfg  = decode(mode_q);

  always_ff @(posedge clk) begin
    if (!hw_rst_n) begin
      {ctrl_q, adv_q, crs_q, rep_q} <= strap_cfg;
      mode_q <= strap_mode;
      lock_q <= (strap_mode == M_SLEEP);
      rmii_q <= strap_rmii;
      srst_q <= 1'b0;
      done_q <= 1'b0;
    end else if (srst_q) begin
      if (!done_q) begin
        {ctrl_q, adv_q, crs_q, rep_q} <= soft_cfg;
        lock_q <= (mode_q == M_SLEEP);
        done_q <= 1'b1;
      end else begin
        srst_q <= 1'b0;
        done_q <= 1'b0;
      end
    end else if (reg_wr) begin
      if (reg_addr == AW'(CTRL_ADDR)) begin
        if (reg_wdata[15]) srst_q <= 1'b1;
        else ctrl_q <= {reg_wdata[13], reg_wdata[12], reg_wdata[10], reg_wdata[8]};
      end else if (reg_addr == AW'(ADV_ADDR)) begin
        adv_q <= reg_wdata[5 +: ADVW];
      end else if (reg_addr == AW'(MODE_ADDR)) begin
        mode_q <= reg_wdata[5 +: MW];
      end
    end
  end

  assign speed_100   = ctrl_q[3];
  assign an_enable   = ctrl_q[2];
  assign pwr_down    = ctrl_q[1] | lock_q;
  assign full_duplex = ctrl_q[0];
  assign adv_abil    = adv_q;
  assign rmii_sel    = rmii_q;
  assign crs_on_tx   = crs_q;
  assign repeater    = rep_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(CTRL_ADDR)) begin
      reg_rdata[15] = srst_q;
      reg_rdata[13] = speed_100;
      reg_rdata[12] = an_enable;
      reg_rdata[10] = pwr_down;
      reg_rdata[8]  = full_duplex;
    end else if (reg_addr == AW'(ADV_ADDR)) begin
      reg_rdata[5 +: ADVW] = adv_q;
    end else if (reg_addr == AW'(MODE_ADDR)) begin
      reg_rdata[5 +: MW] = mode_q;
    end
  end

  p_rmii_hold_r4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $past(hw_rst_n) |-> $stable(rmii_sel));

  p_srst_selfclear_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
    srst_q && done_q |=> !srst_q);

  p_busy_ignores_wr_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
    srst_q && reg_wr |=> $stable(mode_q));

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
    lock_q && !srst_q |=> pwr_down);

  p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
    srst_q && !done_q && mode_q == M_SLEEP |=> pwr_down);

  p_repeater_rx_only_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    repeater |-> !crs_on_tx);
endmodule

// File: tb/test_mode_strap_cfg.sv
module test_mode_strap_cfg;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, hw_rst_n = 0, strap_rmii = 0, reg_wr = 0;
  logic [2:0] strap_mode = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic speed_100, an_enable, full_duplex, pwr_down, rmii_sel, crs_on_tx, repeater;
  logic [3:0] adv_abil;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_strap_cfg i_mode_strap_cfg (.*);

  function automatic logic [3:0] exp_ctrl(input logic [2:0] m);
    case (m)
      3'd0: return 4'b0000; 3'd1: return 4'b0001; 3'd2: return 4'b1000;
      3'd3: return 4'b1001; 3'd4: return 4'b1100; 3'd5: return 4'b1100;
      3'd6: return 4'b0010; default: return 4'b1101;
    endcase
  endfunction
  function automatic logic [3:0] exp_adv(input logic [2:0] m);
    if (m == 3'd4 || m == 3'd5) return 4'b0100;
    if (m == 3'd7) return 4'b1111;
    return 4'b0000;
  endfunction
  function automatic logic exp_crs(input logic [2:0] m);
    return (m == 3'd0 || m == 3'd2 || m == 3'd4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic hw_reset(input logic [2:0] m, input logic r);
    @(negedge clk); hw_rst_n = 0; strap_mode = m; strap_rmii = r;
    reg_wr = 1; reg_addr = 5'd4; reg_wdata = 16'h0000;   // R9 write under reset
    repeat (3) @(negedge clk);
    reg_wr = 0; hw_rst_n = 1;
  endtask

  task automatic check_cfg(input logic [2:0] m, input string tag);
    logic [15:0] d;
    chk({tag, " ctrl"}, {speed_100, an_enable, pwr_down, full_duplex}, exp_ctrl(m));
    chk({tag, " adv"}, adv_abil, exp_adv(m));
    chk({tag, " crs R3"}, crs_on_tx, exp_crs(m));
    chk({tag, " rep R3"}, repeater, m == 3'd5);
    rd(5'd0, d);
    chk({tag, " rd0 R6"}, {d[13], d[12], d[10], d[8]}, exp_ctrl(m));
    rd(5'd4, d);
    chk({tag, " rd4 R6"}, d[8:5], exp_adv(m));
  endtask

  task automatic soft_reset(input bit timing);
    logic [15:0] d;
    wr(5'd0, 16'h8000);
    if (timing) begin rd(5'd0, d); chk("R7 bit set", d[15], 1); end
    @(negedge clk);
    if (timing) begin rd(5'd0, d); chk("R7 bit held", d[15], 1); end
    @(negedge clk);
    rd(5'd0, d); chk("R7 bit clear", d[15], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [2:0] m;
    logic r;
    d = 16'($urandom(32'h5eed));

    hw_reset(3'd7, 1'b1);
    #1;
    check_cfg(3'd7, "R1 R2 R9 reset");
    chk("R4 rmii", rmii_sel, 1);
    rd(5'd18, d); chk("R6 mode load", d[7:5], 3'd7);

    for (int i = 0; i < 8; i++) begin
      r = 1'($urandom);
      hw_reset(3'(i), r);
      #1;
      check_cfg(3'(i), "R1 R2 strap");
      chk("R4 rmii latch", rmii_sel, r);
      strap_mode = 3'($urandom); strap_rmii = ~r;
      repeat (3) @(negedge clk);
      check_cfg(3'(i), "R5 strap ignored");
      chk("R4 rmii hold", rmii_sel, r);
    end

    hw_reset(3'd2, 1'b0);
    for (int i = 0; i < 40; i++) begin
      m = 3'($urandom);
      wr(5'd18, {8'h00, m, 5'h00});
      strap_mode = 3'($urandom);
      soft_reset(i < 4);
      check_cfg(m, "R7 R5 soft");
      chk("R4 soft keeps rmii", rmii_sel, 0);
    end

    hw_reset(3'd1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      d = 16'($urandom) & 16'h3500;
      wr(5'd0, d);
      chk("R6 ctrl write", {speed_100, an_enable, pwr_down, full_duplex},
          {d[13], d[12], d[10], d[8]});
      d = 16'($urandom);
      wr(5'd4, d);
      chk("R6 adv write", adv_abil, d[8:5]);
    end

    hw_reset(3'd4, 1'b0);
    wr(5'd0, 16'h8000);
    reg_wr = 1; reg_addr = 5'd4; reg_wdata = 16'h01e0;
    @(negedge clk); reg_wr = 0;
    @(negedge clk);
    chk("R7 write during soft reset", adv_abil, 4'b0100);

    hw_reset(3'd6, 1'b0);
    #1;
    chk("R8 sleep at strap", pwr_down, 1);
    wr(5'd0, 16'h0000);
    chk("R8 ctrl clear no exit", pwr_down, 1);
    soft_reset(0);
    chk("R8 soft same mode", pwr_down, 1);
    wr(5'd18, {8'h00, 3'd3, 5'h00});
    chk("R8 mode write alone", pwr_down, 1);
    soft_reset(0);
    check_cfg(3'd3, "R8 exit");
    wr(5'd18, {8'h00, 3'd6, 5'h00});
    soft_reset(0);
    chk("R8 sleep via soft", pwr_down, 1);

    rd(5'd1, d); chk("R10 unmapped 1", d, 0);
    rd(5'd31, d); chk("R10 unmapped 31", d, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule